// File: doc/BRIEF.md
# Dual-Mode Expansion Bus Clock Divider

This block derives the expansion-bus clock from a fast reference clock. A 3-bit ratio code and a speed-mode bit together pick the divisor. The same code maps to one divisor set when the fast mode is selected and to a slower set otherwise. Code 000 selects a different source in both modes: a fixed half-rate clock taken from a separate 14.318 MHz oscillator input. The configuration register that feeds the code resets to zero, so the oscillator source is the default.

All logic runs in the reference domain. The oscillator is brought in through a synchronizer, and the output toggles on each detected oscillator rising edge. The reference must therefore run at least four times faster than the oscillator. The output is registered and has a fixed period for every divisor, odd ones included. A new code or mode is taken only at a period boundary, which is the point where the output would next rise. A switch between sources holds the output low until the new source has completed a full period.

A single-cycle enable pulse marks each output rising edge. Logic that stays in the reference domain can use this pulse instead of the divided clock.

Top module: `bus_clk_div`

## Requirements
- R1: While reset is asserted, `bus_clk` and `rise_en` are both low.
- R2: With `ratio_sel` = 000, in either mode, the output period is two oscillator periods. It is high for one oscillator period and low for one, within one reference cycle of jitter.
- R3: With `fast_mode` = 1, codes 001, 010, 011, 100, 101, 110 and 111 divide the reference by 2, 3, 4, 5, 6, 8 and 10 respectively.
- R4: With `fast_mode` = 0, codes 001 through 111 divide the reference by 3, 4, 5, 6, 8, 10 and 12 respectively.
- R5: For a reference divisor N, the output is high for floor(N/2) reference cycles and low for the remaining cycles of each period.
- R6: A change of `ratio_sel` or `fast_mode` does not alter the period in progress. It takes effect from the next period.
- R7: When the source changes, the output stays low until the new source completes a full period. From reference to oscillator, the low gap lasts at least one full oscillator period after the reference low phase. From oscillator to reference, the low gap lasts at least N reference cycles beyond the oscillator low phase.
- R8: `rise_en` is high for exactly one reference cycle: the first cycle in which `bus_clk` is high after being low. It is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock; all state is clocked here |
| clk_osc | input | 1 | 14.318 MHz oscillator, at most a quarter of the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 3 | Ratio code; 000 selects the oscillator source |
| fast_mode | input | 1 | 1 selects the fast divisor set, 0 the normal set |
| bus_clk | output | 1 | Divided bus clock, registered |
| rise_en | output | 1 | One-cycle pulse on each rising edge of `bus_clk` |

## Verification
The bench builds the block with its defaults: a two-flop oscillator synchronizer and a 4-bit counter. The counter width covers the largest divisor, 12. The oscillator runs seven times slower than the reference, which keeps edge detection inside its margin. With these settings the bench can sweep all sixteen mode and code pairs, including odd divisors and both source switches, and then repeat the sweep with random codes.

// File: rtl/bus_clk_div.sv
module bus_clk_div #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic       clk_ref,
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic [2:0] ratio_sel,
  input  logic       fast_mode,
  output logic       bus_clk,
  output logic       rise_en
);

  localparam logic [2:0] OSC_CODE = 3'd0;

  logic [SYNC_STAGES:0] osc_sync;
  logic                 osc_rise;
  logic                 src_osc, hold, out_q, rise_q, out_d;
  logic [CNT_W-1:0]     div, cnt, hi_cnt, req_div;
  logic                 req_osc, bnd, switching;

  function automatic logic [CNT_W-1:0] pick_div(input logic fast, input logic [2:0] code);
    logic [CNT_W-1:0] r;
    case ({fast, code})
      4'b1_001: r = CNT_W'(2);
      4'b1_010, 4'b0_001: r = CNT_W'(3);
      4'b1_011, 4'b0_010: r = CNT_W'(4);
      4'b1_100, 4'b0_011: r = CNT_W'(5);
      4'b1_101, 4'b0_100: r = CNT_W'(6);
      4'b1_110, 4'b0_101: r = CNT_W'(8);
      4'b1_111, 4'b0_110: r = CNT_W'(10);
      4'b0_111: r = CNT_W'(12);
      default:  r = CNT_W'(2);
    endcase
    return r;
  endfunction

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) osc_sync <= '0;
    else        osc_sync <= {osc_sync[SYNC_STAGES-1:0], clk_osc};

  assign osc_rise  = osc_sync[SYNC_STAGES-1] & ~osc_sync[SYNC_STAGES];
  assign req_osc   = (ratio_sel == OSC_CODE);
  assign req_div   = pick_div(fast_mode, ratio_sel);
  assign hi_cnt    = div >> 1;
  assign bnd       = src_osc ? (osc_rise && !out_q) : (cnt == div - 1'b1);
  assign switching = bnd && (req_osc != src_osc);

  always_comb begin
    if (bnd)
      out_d = !switching && !(src_osc && hold);
    else if (src_osc)
      out_d = (osc_rise && out_q) ? 1'b0 : out_q;
    else
      out_d = !hold && ((cnt + 1'b1) < hi_cnt);
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      src_osc <= 1'b1;
      hold    <= 1'b1;
      div     <= CNT_W'(2);
      cnt     <= '0;
      out_q   <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      out_q  <= out_d;
      rise_q <= out_d & ~out_q;
      if (bnd) begin
        src_osc <= req_osc;
        div     <= req_div;
        hold    <= switching;
        cnt     <= '0;
      end else begin
        cnt <= src_osc ? '0 : cnt + 1'b1;
      end
    end
  end

  assign bus_clk = out_q;
  assign rise_en = rise_q;

  AST_RISE_ONCE: assert property (@(posedge clk_ref) disable iff (!rst_n) $rose(out_q) == rise_q); // R8
  AST_CNT_RANGE: assert property (@(posedge clk_ref) disable iff (!rst_n) !src_osc |-> cnt < div); // R5
  AST_HOLD_LOW:  assert property (@(posedge clk_ref) disable iff (!rst_n) hold |-> !out_q); // R7
  AST_OSC_EDGE:  assert property (@(posedge clk_ref) disable iff (!rst_n) (src_osc && !osc_rise) |=> $stable(out_q)); // R2
  AST_CFG_AT_END: assert property (@(posedge clk_ref) disable iff (!rst_n) !bnd |=> ($stable(div) && $stable(src_osc))); // R6

endmodule

// File: tb/tb_bus_clk_div.sv
module tb_bus_clk_div;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_HALF   = 35;
  localparam int OSC_REF    = 14;

  logic clk_ref = 0, clk_osc = 0, rst_n = 0;
  logic [2:0] ratio_sel = 3'd0;
  logic fast_mode = 0;
  logic bus_clk, rise_en;

  int checks = 0, errors = 0;
  int since = 0, hicnt = 0, per_last = 0, hi_last = 0, lowrun = 0, gap_last = 0;
  logic prev_clk = 0;

  bus_clk_div dut (.clk_ref(clk_ref), .clk_osc(clk_osc), .rst_n(rst_n),
                   .ratio_sel(ratio_sel), .fast_mode(fast_mode),
                   .bus_clk(bus_clk), .rise_en(rise_en));

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;
  initial begin #3; forever #(OSC_HALF) clk_osc = ~clk_osc; end

  function automatic int exp_div(bit fast, int code);
    int normal[7] = '{3, 4, 5, 6, 8, 10, 12};
    if (code == 0) return 0;
    if (!fast) return normal[code-1];
    if (code == 1) return 2;
    return normal[code-2];
  endfunction

  task automatic chk(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  always @(negedge clk_ref) if (rst_n) begin
    checks++;
    if (rise_en !== (bus_clk && !prev_clk)) begin
      errors++;
      $display("FAIL R8: rise_en %0b expected %0b", rise_en, bus_clk && !prev_clk);
    end
    prev_clk <= bus_clk;
    if (rise_en) begin
      per_last <= since; hi_last <= hicnt; gap_last <= lowrun;
      since <= 1; hicnt <= 1;
    end else begin
      since <= since + 1;
      if (bus_clk) hicnt <= hicnt + 1;
    end
    lowrun <= bus_clk ? 0 : lowrun + 1;
  end

  task automatic next_rise();
    do @(negedge clk_ref); while (!rise_en);
    #1;
  endtask

  task automatic measure(bit fast, int code);
    int n;
    fast_mode = fast; ratio_sel = 3'(code);
    repeat (3) next_rise();
    n = exp_div(fast, code);
    if (n == 0) begin
      chk("R2 period", per_last, OSC_REF-1, OSC_REF+1);
      chk("R2 high", hi_last, OSC_REF/2-1, OSC_REF/2+1);
    end else begin
      chk(fast ? "R3 period" : "R4 period", per_last, n, n);
      chk("R5 high", hi_last, n/2, n/2);
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk_ref);
    chk("R1 bus_clk", int'(bus_clk), 0, 0);
    chk("R1 rise_en", int'(rise_en), 0, 0);
    rst_n = 1;

    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 8; c++) measure(bit'(m), c);

    // R6: change mid-period, old period completes
    measure(1'b0, 7);
    repeat (3) @(negedge clk_ref);
    ratio_sel = 3'd2;
    next_rise(); chk("R6 old period", per_last, 12, 12);
    next_rise(); chk("R6 new period", per_last, 4, 4);

    // R7: reference -> oscillator
    measure(1'b0, 7);
    ratio_sel = 3'd0;
    next_rise(); chk("R7 ref->osc gap", gap_last, 6 + OSC_REF/2 - 1, 1000);
    // R7: oscillator -> reference
    repeat (2) next_rise();
    ratio_sel = 3'd3;
    next_rise(); chk("R7 osc->ref gap", gap_last, 5 + 5, 1000);
    next_rise(); chk("R7 first period", per_last, 5, 5);

    for (int i = 0; i < 24; i++) measure(bit'($urandom % 2), int'($urandom % 8));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule